// File: doc/BRIEF.md
# Prioritised Peripheral Interrupt Arbiter

This block collects interrupt events from a set of on-chip peripheral channels and presents one request to the processor core. Each channel holds a pending flag, which a one-cycle hardware event pulse sets. Software can also force it on or off through a small write port and can poll it on `pend_o`. Each channel has a mask bit, a 3-bit urgency level and a vector of up to 7 bits.

Among the channels that are pending, unmasked and below the lowest level, the arbiter picks the one with the smallest level number. A tie goes to the lower channel index. The winner's vector, level and index are driven to the core. The request is forwarded only under three conditions: the global enable is on, the winner is strictly more urgent than the core's current level, and no top-level routine is in service.

When the core acknowledges, the winner's pending flag is cleared. The core then loads the level output as its new current level.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A one-cycle pulse on `trig_i[c]` sets pending flag c, and `pend_o[c]` reads 1 from the next cycle on.
- R2: A software write (`sw_wr_i`=1) copies `sw_val_i` into the pending flag of channel `sw_ch_i`: 1 raises the interrupt and 0 cancels it.
- R3: A channel takes part in a request only when its pending flag is 1 and its mask bit is 1. `req_o` is 0 whenever `glob_en_i` is 0.
- R4: A channel whose level is 7 is never requested or granted, even when it is pending and unmasked. It does not block the other channels.
- R5: The winner is the eligible channel with the smallest level number. On a tie the lowest index wins. `req_ch_o`, `req_vec_o` and `req_prio_o` carry that channel's index, vector and level.
- R6: `req_o` is 1 only if the winner's level is strictly less than `cur_lvl_i`.
- R7: While `top_busy_i` is 1, `req_o` is 0.
- R8: `ack_i`=1 while `req_o`=1 clears only the winner's pending flag, from the next cycle on. `ack_i` while `req_o`=0 changes no flag.
- R9: A hardware pulse on a channel wins over a software clear or an acknowledge clear of the same flag in the same cycle, and the flag stays 1.
- R10: After reset, all pending flags read 0 and `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | NUM_CH | Per-channel hardware event pulse |
| mask_i | input | NUM_CH | Per-channel enable mask (1 = may request) |
| prio_i | input | NUM_CH*3 | Per-channel level, channel c in bits [3c+2:3c]; 0 most urgent, 7 never served |
| vec_i | input | NUM_CH*VEC_W | Per-channel vector, channel c in bits [VEC_W*c +: VEC_W] |
| glob_en_i | input | 1 | Global interrupt enable |
| cur_lvl_i | input | 3 | Core's current level |
| top_busy_i | input | 1 | Top-level routine in service; blocks all requests |
| sw_wr_i | input | 1 | Software write strobe to a pending flag |
| sw_ch_i | input | $clog2(NUM_CH) | Channel addressed by the software write |
| sw_val_i | input | 1 | Value written (1 set, 0 clear) |
| ack_i | input | 1 | Core acknowledge of the current request |
| pend_o | output | NUM_CH | Pending flags, for polling |
| req_o | output | 1 | Request to the core |
| req_ch_o | output | $clog2(NUM_CH) | Index of the winning channel |
| req_vec_o | output | VEC_W | Vector of the winning channel |
| req_prio_o | output | 3 | Level of the winning channel |

## Verification
The bench targets level ties between channels. An arbiter that scanned from the top index would grant channel 2 instead of channel 1. It also runs a winner whose level equals the current level, which a non-strict compare would wrongly forward. Level-7 channels are checked both alone and alongside a serviceable channel, to catch a design that grants them or lets them hide others. Same-cycle collisions of a hardware pulse with a software clear or an acknowledge would lose a real event if the clear took precedence. An acknowledge while no request is up must not silently drop a pending flag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Level field width is fixed by the programming model.
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;
  // Least urgent level: never acknowledged.
  localparam prio_t PRIO_NEVER = '1;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic              sw_wr_i,
  input  logic [IDX_W-1:0]  sw_ch_i,
  input  logic              sw_val_i,
  input  logic              ack_hit_i,
  input  logic [IDX_W-1:0]  ack_ch_i,
  output logic [NUM_CH-1:0] pend_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sw_hit, clr_hit, nxt, en, q;

    always_comb begin
      sw_hit  = sw_wr_i && (sw_ch_i == IDX_W'(c));
      clr_hit = ack_hit_i && (ack_ch_i == IDX_W'(c));
      en      = trig_i[c] | sw_hit | clr_hit;
      nxt     = q;
      if (sw_hit)    nxt = sw_val_i;
      if (clr_hit)   nxt = 1'b0;
      if (trig_i[c]) nxt = 1'b1;   // hardware event has the last word
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= nxt;
    end

    assign pend_o[c] = q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VEC_W  = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]        pend_i,
  input  logic [NUM_CH-1:0]        mask_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH*VEC_W-1:0]  vec_i,
  output logic                     win_vld_o,
  output logic [IDX_W-1:0]         win_ch_o,
  output prio_t                    win_prio_o,
  output logic [VEC_W-1:0]         win_vec_o
);
  logic [NUM_CH-1:0] elig;
  prio_t             lvl [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    assign lvl[c]  = prio_i[c*PRIO_W +: PRIO_W];
    assign elig[c] = pend_i[c] & mask_i[c] & (lvl[c] != PRIO_NEVER);
  end

  // Linear scan; strict compare keeps the lowest index on ties.
  always_comb begin
    win_vld_o  = 1'b0;
    win_ch_o   = '0;
    win_prio_o = PRIO_NEVER;
    win_vec_o  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (elig[c] && (!win_vld_o || (lvl[c] < win_prio_o))) begin
        win_vld_o  = 1'b1;
        win_ch_o   = IDX_W'(c);
        win_prio_o = lvl[c];
        win_vec_o  = vec_i[c*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_grant_gate.sv
module irq_grant_gate
  import irq_arb_pkg::*;
(
  input  logic  win_vld_i,
  input  prio_t win_prio_i,
  input  prio_t cur_lvl_i,
  input  logic  glob_en_i,
  input  logic  top_busy_i,
  input  logic  ack_i,
  output logic  req_o,
  output logic  ack_hit_o
);
  always_comb begin
    req_o     = win_vld_i && glob_en_i && !top_busy_i && (win_prio_i < cur_lvl_i);
    ack_hit_o = req_o && ack_i;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VEC_W  = 7,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        trig_i,
  input  logic [NUM_CH-1:0]        mask_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic [NUM_CH*VEC_W-1:0]  vec_i,
  input  logic                     glob_en_i,
  input  logic [PRIO_W-1:0]        cur_lvl_i,
  input  logic                     top_busy_i,
  input  logic                     sw_wr_i,
  input  logic [IDX_W-1:0]         sw_ch_i,
  input  logic                     sw_val_i,
  input  logic                     ack_i,
  output logic [NUM_CH-1:0]        pend_o,
  output logic                     req_o,
  output logic [IDX_W-1:0]         req_ch_o,
  output logic [VEC_W-1:0]         req_vec_o,
  output logic [PRIO_W-1:0]        req_prio_o
);
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  logic       win_vld, ack_hit;
  prio_t      win_prio;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  irq_pend_bank #(.NUM_CH(NUM_CH)) u_pend (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .trig_i   (trig_i),
    .sw_wr_i  (sw_wr_i),
    .sw_ch_i  (sw_ch_i),
    .sw_val_i (sw_val_i),
    .ack_hit_i(ack_hit),
    .ack_ch_i (req_ch_o),
    .pend_o   (pend_o)
  );

  irq_prio_pick #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_pick (
    .pend_i    (pend_o),
    .mask_i    (mask_i),
    .prio_i    (prio_i),
    .vec_i     (vec_i),
    .win_vld_o (win_vld),
    .win_ch_o  (req_ch_o),
    .win_prio_o(win_prio),
    .win_vec_o (req_vec_o)
  );

  irq_grant_gate u_gate (
    .win_vld_i (win_vld),
    .win_prio_i(win_prio),
    .cur_lvl_i (cur_lvl_i),
    .glob_en_i (glob_en_i),
    .top_busy_i(top_busy_i),
    .ack_i     (ack_i),
    .req_o     (req_o),
    .ack_hit_o (ack_hit)
  );

  assign req_prio_o = win_prio;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] trig_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic              glob_en_i,
  input logic [2:0]        cur_lvl_i,
  input logic              top_busy_i,
  input logic              sw_wr_i,
  input logic [IDX_W-1:0]  sw_ch_i,
  input logic              sw_val_i,
  input logic              ack_i,
  input logic [NUM_CH-1:0] pend_o,
  input logic              req_o,
  input logic [IDX_W-1:0]  req_ch_o,
  input logic [2:0]        req_prio_o
);
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    top_busy_i |-> !req_o); // R7

  AST_STRICT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (req_prio_o < cur_lvl_i)); // R6

  AST_NEVER_LVL7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (req_prio_o != 3'd7)); // R4

  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (glob_en_i && pend_o[req_ch_o] && mask_i[req_ch_o])); // R3

  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(trig_i)) == $past(trig_i))); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i && !trig_i[req_ch_o] && !(sw_wr_i && sw_val_i && (sw_ch_i == req_ch_o)))
    |=> !pend_o[$past(req_ch_o)]); // R8
endmodule

bind irq_prio_arbiter irq_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .trig_i    (trig_i),
  .mask_i    (mask_i),
  .glob_en_i (glob_en_i),
  .cur_lvl_i (cur_lvl_i),
  .top_busy_i(top_busy_i),
  .sw_wr_i   (sw_wr_i),
  .sw_ch_i   (sw_ch_i),
  .sw_val_i  (sw_val_i),
  .ack_i     (ack_i),
  .pend_o    (pend_o),
  .req_o     (req_o),
  .req_ch_o  (req_ch_o),
  .req_prio_o(req_prio_o)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
  localparam int N = 8;
  localparam int VW = 7;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rst_n;
  logic [N-1:0]  trig, mask;
  logic [N*3-1:0] prio;
  logic [N*VW-1:0] vec;
  logic          glob_en, busy, sw_wr, sw_val, ack;
  logic [2:0]    cur_lvl;
  logic [IW-1:0] sw_ch;
  logic [N-1:0]  pend;
  logic          req;
  logic [IW-1:0] req_ch;
  logic [VW-1:0] req_vec;
  logic [2:0]    req_prio;

  irq_prio_arbiter #(.NUM_CH(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .mask_i(mask), .prio_i(prio),
    .vec_i(vec), .glob_en_i(glob_en), .cur_lvl_i(cur_lvl), .top_busy_i(busy),
    .sw_wr_i(sw_wr), .sw_ch_i(sw_ch), .sw_val_i(sw_val), .ack_i(ack),
    .pend_o(pend), .req_o(req), .req_ch_o(req_ch), .req_vec_o(req_vec),
    .req_prio_o(req_prio)
  );

  // Channel levels: ch0=5 ch1=3 ch2=3 ch3=7 ch4=2 ch5=6 ch6=2 ch7=0
  localparam logic [2:0] LVL [N] = '{3'd5, 3'd3, 3'd3, 3'd7, 3'd2, 3'd6, 3'd2, 3'd0};

  int n_chk = 0;
  int n_err = 0;

  function automatic logic [VW-1:0] exp_vec(input int c);
    return VW'(8'h40 + 3 * c);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) begin
      @(negedge clk); sw_wr = 1'b1; sw_ch = IW'(c); sw_val = 1'b0;
    end
    @(negedge clk); sw_wr = 1'b0;
  endtask

  task automatic load(input logic [N-1:0] p);
    clear_all();
    trig = p;
    @(negedge clk); trig = '0;
  endtask

  // Row: pend, mask, level, enable, busy, expected req, expected channel
  typedef struct packed {
    logic [7:0] pnd; logic [7:0] msk; logic [2:0] lv;
    logic en; logic bz; logic xr; logic [2:0] xc;
  } row_t;

  localparam int ROWS = 11;
  localparam row_t TBL [ROWS] = '{
    '{8'h06, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b1, 3'd1},  // R5 tie -> lower index
    '{8'h50, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b1, 3'd4},  // R5 tie
    '{8'h81, 8'h7F, 3'd7, 1'b1, 1'b0, 1'b1, 3'd0},  // R3 ch7 masked
    '{8'h08, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0},  // R4 level 7 alone
    '{8'h09, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b1, 3'd0},  // R4 does not block ch0
    '{8'h10, 8'hFF, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0},  // R6 equal level
    '{8'h10, 8'hFF, 3'd3, 1'b1, 1'b0, 1'b1, 3'd4},  // R6 one below
    '{8'h80, 8'hFF, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 global enable off
    '{8'h80, 8'hFF, 3'd7, 1'b1, 1'b1, 1'b0, 3'd0},  // R7 top-level busy
    '{8'hFF, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b1, 3'd7},  // R5 all pending
    '{8'h00, 8'hFF, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0}   // R3 nothing pending
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; trig = '0; mask = '1; glob_en = 1'b1; busy = 1'b0;
    sw_wr = 1'b0; sw_val = 1'b0; sw_ch = '0; ack = 1'b0; cur_lvl = 3'd7;
    for (int c = 0; c < N; c++) begin
      prio[c*3 +: 3]  = LVL[c];
      vec[c*VW +: VW] = exp_vec(c);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(pend == '0, "R10 pend after reset", int'(pend), 0);
    chk(req == 1'b0, "R10 req after reset", int'(req), 0);

    // Vector table
    for (int r = 0; r < ROWS; r++) begin
      load(TBL[r].pnd);
      mask = TBL[r].msk; cur_lvl = TBL[r].lv; glob_en = TBL[r].en; busy = TBL[r].bz;
      #1;
      chk(pend == TBL[r].pnd, "R1 pulse sets pending", int'(pend), int'(TBL[r].pnd));
      chk(req == TBL[r].xr, "R3/R5 request", int'(req), int'(TBL[r].xr));
      if (TBL[r].xr) begin
        chk(req_ch == TBL[r].xc, "R5 winner index", int'(req_ch), int'(TBL[r].xc));
        chk(req_vec == exp_vec(int'(TBL[r].xc)), "R5 winner vector",
            int'(req_vec), int'(exp_vec(int'(TBL[r].xc))));
        chk(req_prio == LVL[TBL[r].xc], "R5 winner level",
            int'(req_prio), int'(LVL[TBL[r].xc]));
      end
      mask = '1; cur_lvl = 3'd7; glob_en = 1'b1; busy = 1'b0;
    end

    // R2: software raise and cancel
    clear_all();
    @(negedge clk); sw_wr = 1'b1; sw_ch = 3'd5; sw_val = 1'b1;
    @(negedge clk); sw_wr = 1'b0; #1;
    chk(pend == 8'h20, "R2 software set", int'(pend), 'h20);
    chk(req && req_ch == 3'd5, "R2 forced request ch5", int'(req_ch), 5);
    @(negedge clk); sw_wr = 1'b1; sw_ch = 3'd5; sw_val = 1'b0;
    @(negedge clk); sw_wr = 1'b0; #1;
    chk(pend == 8'h00, "R2 software clear", int'(pend), 0);
    chk(req == 1'b0, "R2 request cancelled", int'(req), 0);

    // R8: acknowledge clears only the winner
    load(8'h50); #1;
    chk(req && req_ch == 3'd4, "R8 winner before ack", int'(req_ch), 4);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0; #1;
    chk(pend == 8'h40, "R8 ack clears winner only", int'(pend), 'h40);
    chk(req && req_ch == 3'd6 && req_prio == 3'd2, "R8 next winner ch6", int'(req_ch), 6);
    busy = 1'b1; ack = 1'b1;
    @(negedge clk); ack = 1'b0; busy = 1'b0; #1;
    chk(pend == 8'h40, "R8 ack without request ignored", int'(pend), 'h40);

    // R9: hardware set against software clear, then against ack clear
    clear_all();
    @(negedge clk); trig = 8'h04; sw_wr = 1'b1; sw_ch = 3'd2; sw_val = 1'b0;
    @(negedge clk); trig = '0; sw_wr = 1'b0; #1;
    chk(pend == 8'h04, "R9 trig beats software clear", int'(pend), 'h04);
    chk(req && req_ch == 3'd2, "R9 ch2 requesting", int'(req_ch), 2);
    trig = 8'h04; ack = 1'b1;
    @(negedge clk); trig = '0; ack = 1'b0; #1;
    chk(pend == 8'h04, "R9 trig beats ack clear", int'(pend), 'h04);

    // R3: masked pending channel stays silent, flag still readable
    mask = 8'hFB; #1;
    chk(req == 1'b0, "R3 masked channel no request", int'(req), 0);
    chk(pend == 8'h04, "R3 masked flag kept", int'(pend), 'h04);
    mask = '1;

    // R10: reset mid-run clears flags
    rst_n = 1'b0; #1;
    chk(pend == '0, "R10 reset clears pending", int'(pend), 0);
    chk(req == 1'b0, "R10 reset drops request", int'(req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    report();
  end
endmodule